// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one external machine cycle for an 8-bit processor core that addresses 64 KiB. The core presents a request with a cycle kind, a 16-bit address and a write byte. The block then drives the pins in a fixed order. The first clock puts the low address byte on a shared address/data bus, with an address-latch pulse. The following clocks carry data on those same pins. The core gets back a one-clock done pulse and, for reads, the captured byte.

On the pin side there is a dedicated high address byte and the shared byte, which has separate out, in and enable lines. There are active-low read and write strobes, an I/O-versus-memory select and a two-bit status code that is valid while the latch pulse is high. A slow device stretches the cycle by holding `ready` low. Another bus master can ask for the bus with `hold`. The block grants it with `hlda` once the current cycle has finished, and releases all shared lines while the grant lasts.

Top module: `mux_bus_seq`

## Requirements
- R1: In the first clock of a non-halt cycle, `ale` is 1 for exactly that clock, `ad_oe` is 1 and `ad_out` carries `req_addr[7:0]`. For memory cycles `bus_ahi` carries `req_addr[15:8]`. The request is accepted on the clock edge where `req_valid` and `req_ready` are both 1, and this first clock starts on that edge.
- R2: `req_kind` encodes 0 = opcode fetch, 1 = memory read, 2 = memory write, 3 = I/O read, 4 = I/O write, and 5 to 7 = halt. `stat` shows 11 for fetch, 10 for reads, 01 for writes and 00 for halt, and holds that value until the next request. `io_sel` is 1 exactly for kinds 3 and 4. After reset `stat` is 11.
- R3: In an I/O cycle the port number `req_addr[7:0]` appears on both `bus_ahi` and `ad_out` during the first clock.
- R4: For fetch and read kinds, `rd_n` is 0 in the second clock and in every wait clock, and 1 otherwise. `ad_oe` is 0 from the second clock through the end of the cycle. `ad_in` is captured at the end of the last strobe clock.
- R5: For write kinds, `wr_n` is 0 in the second clock and in every wait clock. `ad_out` carries the write byte with `ad_oe` 1 from the second clock through the clock after `wr_n` rises.
- R6: If `ready` is 0 at the end of a strobe clock, the strobe clock repeats. The cycle moves on to its last clock only after a strobe clock ends with `ready` at 1. `ready` has no effect outside strobe clocks.
- R7: `rsp_done` is 1 for one clock, in the clock after the last clock of a cycle. `rsp_rdata` then holds the byte read and keeps it until the next read.
- R8: A `hold` seen at the end of a cycle, or while idle or halted, makes `hlda` 1 from the next clock. While `hlda` is 1, `bus_ctl_oe` and `ad_oe` are 0. `hlda` never rises inside a cycle.
- R9: When `hold` is seen low during the grant, `hlda` drops in the next clock. The bus lines stay released for that one further clock and are then driven again. After that the block returns to idle, or to halt if the grant was taken while halted.
- R10: A halt request gives a one-clock `ale` with `stat` 00, no strobes and `bus_ctl_oe` and `ad_oe` at 0. `rsp_done` follows in the next clock. The block then stays halted with the bus released until a new request or a `hold` arrives.
- R11: `req_ready` is 1 only when the block is idle or halted and `hold` is 0. While it is 0, a pending request leaves every output unchanged and is taken once `req_ready` returns to 1.
- R12: While `rst_n` is 0, the block is idle. `ale`, `hlda`, `ad_oe` and `rsp_done` are 0, `rd_n` and `wr_n` are 1, `bus_ctl_oe` is 1 and `stat` is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core requests a machine cycle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address (port number in low byte for I/O) |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request can be taken this clock |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| bus_ahi | output | 8 | High address byte pins |
| bus_ctl_oe | output | 1 | Enable for bus_ahi, rd_n, wr_n, io_sel |
| ad_out | output | 8 | Shared bus outgoing value |
| ad_in | input | 8 | Shared bus incoming value |
| ad_oe | output | 1 | Shared bus output enable |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_sel | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| stat | output | 2 | Cycle kind status code |
| ready | input | 1 | Device ready; low adds wait clocks |
| hold | input | 1 | Other master requests the bus |
| hlda | output | 1 | Bus granted to the other master |

## Verification
The properties assume that `ready`, `hold` and `req_valid` are synchronous to `clk` and settle well before each rising edge. They also assume that `ad_in` is only meaningful while a read strobe is low. The stimulus changes every input one nanosecond after a rising edge and drives `ready` low only a bounded number of times per cycle. It sets `hold` at idle, inside a cycle and during halt, and keeps a request pending across a grant, so every path into and out of the grant is taken. Outside strobe clocks, `ready` toggles freely, which shows that it is ignored there.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_kind,
  input  logic [2*DW-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_rdata,
  output logic [DW-1:0]   bus_ahi,
  output logic            bus_ctl_oe,
  output logic [DW-1:0]   ad_out,
  input  logic [DW-1:0]   ad_in,
  output logic            ad_oe,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            io_sel,
  output logic [1:0]      stat,
  input  logic            ready,
  input  logic            hold,
  output logic            hlda
);
  localparam int AW = 2 * DW;
  localparam logic [2:0] K_FETCH = 3'd0;
  localparam logic [2:0] K_MRD   = 3'd1;
  localparam logic [2:0] K_MWR   = 3'd2;
  localparam logic [2:0] K_IORD  = 3'd3;
  localparam logic [2:0] K_IOWR  = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_STB, S_TAIL, S_HALT, S_GRANT, S_REGAIN
  } st_t;

  st_t           st;
  logic [2:0]    kind_r;
  logic [AW-1:0] addr_r;
  logic [DW-1:0] wdata_r;
  logic [DW-1:0] rdata_r;
  logic          done_r;
  logic          halted_r;

  logic k_fetch, k_rd, k_wr, k_io, k_halt, in_data;

  assign k_fetch = kind_r == K_FETCH;
  assign k_rd    = k_fetch || kind_r == K_MRD || kind_r == K_IORD;
  assign k_wr    = kind_r == K_MWR || kind_r == K_IOWR;
  assign k_io    = kind_r == K_IORD || kind_r == K_IOWR;
  assign k_halt  = !(k_rd || k_wr);
  assign in_data = st == S_STB || st == S_TAIL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind_r   <= K_FETCH;
      addr_r   <= '0;
      wdata_r  <= '0;
      rdata_r  <= '0;
      done_r   <= 1'b0;
      halted_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE, S_HALT: begin
          if (hold) begin
            st <= S_GRANT;
          end else if (req_valid) begin
            kind_r   <= req_kind;
            addr_r   <= req_addr;
            wdata_r  <= req_wdata;
            halted_r <= 1'b0;
            st       <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (k_halt) begin
            st       <= S_HALT;
            halted_r <= 1'b1;
            done_r   <= 1'b1;
          end else begin
            st <= S_STB;
          end
        end
        S_STB: begin
          if (ready) begin
            if (k_rd) rdata_r <= ad_in;
            st <= S_TAIL;
          end
        end
        S_TAIL: begin
          done_r <= 1'b1;
          st     <= hold ? S_GRANT : S_IDLE;
        end
        S_GRANT: begin
          if (!hold) st <= S_REGAIN;
        end
        S_REGAIN: st <= halted_r ? S_HALT : S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE || st == S_HALT) && !hold;
  assign rsp_done   = done_r;
  assign rsp_rdata  = rdata_r;
  assign hlda       = st == S_GRANT;
  assign bus_ctl_oe = !(st == S_GRANT || st == S_REGAIN) && !k_halt;
  assign ale        = st == S_ADDR;
  assign ad_oe      = bus_ctl_oe && (st == S_ADDR || (k_wr && in_data));
  assign ad_out     = (st == S_ADDR) ? addr_r[DW-1:0] : wdata_r;
  assign bus_ahi    = k_io ? addr_r[DW-1:0] : addr_r[AW-1:DW];
  assign rd_n       = !(k_rd && st == S_STB);
  assign wr_n       = !(k_wr && st == S_STB);
  assign io_sel     = k_io;
  assign stat       = k_fetch ? 2'b11 : k_rd ? 2'b10 : k_wr ? 2'b01 : 2'b00;
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [DW-1:0] bus_ahi,
  input logic          bus_ctl_oe,
  input logic [DW-1:0] ad_out,
  input logic          ad_oe,
  input logic          ale,
  input logic          rd_n,
  input logic          wr_n,
  input logic          io_sel,
  input logic          ready,
  input logic          hlda
);
  a_r1_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  a_r3_io_port_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && io_sel && bus_ctl_oe) |-> bus_ahi == ad_out);
  a_r4_read_bus_input: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r5_wdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> (ad_oe && $stable(ad_out)));
  a_r6_wait_keeps_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !ready) |=> !rd_n);
  a_r8_grant_released: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_ctl_oe && !ad_oe));
  a_r8_no_grant_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !hlda);
  a_r11_ready_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !hlda);
endmodule

bind mux_bus_seq mux_bus_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_ahi(bus_ahi),
  .bus_ctl_oe(bus_ctl_oe), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
  .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel), .ready(ready), .hlda(hlda)
);

// File: tb/sim_mux_bus_seq.sv
`timescale 1ns/1ps
module sim_mux_bus_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, hold = 1'b0, ready = 1'b1;
  logic [2:0] req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic req_ready, rsp_done, bus_ctl_oe, ad_oe, ale, rd_n, wr_n, io_sel, hlda;
  logic [7:0] rsp_rdata, bus_ahi, ad_out;
  logic [1:0] stat;

  mux_bus_seq u0 (.*);

  always #2.5 clk = ~clk;

  int npass = 0, nfail = 0, cyc = 0;
  int ph = 0, wait_cnt = 0, waits_req = 0;
  logic [2:0] mk = 3'd0;
  logic [15:0] ma = '0;
  logic [7:0] mw = '0, mrd = '0;
  logic mdone = 1'b0, mhalted = 1'b0, rdy_neg = 1'b0;

  function automatic bit f_rd(input logic [2:0] k); return k == 0 || k == 1 || k == 3; endfunction
  function automatic bit f_wr(input logic [2:0] k); return k == 2 || k == 4; endfunction
  function automatic bit f_io(input logic [2:0] k); return k == 3 || k == 4; endfunction
  function automatic logic [1:0] f_st(input logic [2:0] k);
    if (k == 0) return 2'b11;
    if (f_rd(k)) return 2'b10;
    if (f_wr(k)) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    if (ok) npass++;
    else begin
      nfail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      ph <= 0; mk <= 3'd0; ma <= '0; mw <= '0; mrd <= '0; mdone <= 1'b0; mhalted <= 1'b0;
    end else begin
      mdone <= (ph == 3) || (ph == 1 && !(f_rd(mk) || f_wr(mk)));
      if (ph == 0 || ph == 10) begin
        if (hold) ph <= 20;
        else if (req_valid) begin
          mk <= req_kind; ma <= req_addr; mw <= req_wdata;
          wait_cnt <= waits_req; mhalted <= 1'b0; ph <= 1;
        end
      end else if (ph == 1) begin
        if (!(f_rd(mk) || f_wr(mk))) begin ph <= 10; mhalted <= 1'b1; end
        else ph <= 2;
      end else if (ph == 2) begin
        if (ready) begin
          if (f_rd(mk)) mrd <= ad_in;
          ph <= 3;
        end else wait_cnt <= wait_cnt - 1;
      end else if (ph == 3) ph <= hold ? 20 : 0;
      else if (ph == 20) begin if (!hold) ph <= 21; end
      else if (ph == 21) ph <= mhalted ? 10 : 0;
    end
  end

  // compare on the falling edge, then drive ready and ad_in
  always @(negedge clk) begin
    bit ctl, aoe;
    rdy_neg = req_ready;
    if (rst_n) begin
      ctl = (ph < 20) && (f_rd(mk) || f_wr(mk));
      aoe = ctl && (ph == 1 || (f_wr(mk) && (ph == 2 || ph == 3)));
      chk(ale == (ph == 1), "R1 ale", ale, ph == 1);
      chk(stat == f_st(mk), "R2 stat", stat, f_st(mk));
      chk(io_sel == f_io(mk), "R2 io_sel", io_sel, f_io(mk));
      chk(bus_ctl_oe == ctl, "R8/R10 bus_ctl_oe", bus_ctl_oe, ctl);
      chk(ad_oe == aoe, "R1/R4 ad_oe", ad_oe, aoe);
      if (aoe && ph == 1) chk(ad_out == ma[7:0], "R1/R3 ad_out addr", ad_out, ma[7:0]);
      if (aoe && ph != 1) chk(ad_out == mw, "R5 ad_out data", ad_out, mw);
      if (ctl) chk(bus_ahi == (f_io(mk) ? ma[7:0] : ma[15:8]), "R1/R3 bus_ahi", bus_ahi,
                   f_io(mk) ? ma[7:0] : ma[15:8]);
      chk(rd_n == !(f_rd(mk) && ph == 2), "R4/R6 rd_n", rd_n, !(f_rd(mk) && ph == 2));
      chk(wr_n == !(f_wr(mk) && ph == 2), "R5/R6 wr_n", wr_n, !(f_wr(mk) && ph == 2));
      chk(hlda == (ph == 20), "R8/R9 hlda", hlda, ph == 20);
      chk(req_ready == ((ph == 0 || ph == 10) && !hold), "R11 req_ready", req_ready,
          (ph == 0 || ph == 10) && !hold);
      chk(rsp_done == mdone, "R7 rsp_done", rsp_done, mdone);
      chk(rsp_rdata == mrd, "R7 rsp_rdata", rsp_rdata, mrd);
    end
    // R6: ready only matters in strobe clocks; elsewhere it toggles
    ready = (ph == 2) ? (wait_cnt == 0) : cyc[1];
    ad_in = ma[7:0] ^ 8'hC3 ^ 8'(cyc);
  end

  always @(posedge clk) if (cyc > 20000) begin
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic wait_accept();
    forever begin
      @(posedge clk);
      if (rdy_neg) break;
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    while (!(ph == 0 || ph == 10)) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic issue(input logic [2:0] k, input logic [15:0] a, input logic [7:0] w,
                       input int nw, input bit hold_after);
    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = w; waits_req = nw;
    wait_accept();
    if (hold_after) hold = 1'b1;
    else drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: outputs under reset
    chk(!ale && !hlda && !ad_oe && !rsp_done && rd_n && wr_n && bus_ctl_oe && stat == 2'b11
        && req_ready, "R12 reset state", {ale, hlda, ad_oe, rsp_done, rd_n, wr_n, stat}, 8'b00001111);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    issue(3'd0, 16'h1234, 8'h00, 0, 0);   // R1 fetch
    issue(3'd1, 16'hABCD, 8'h00, 2, 0);   // R4 R6 read with waits
    issue(3'd2, 16'h5566, 8'h9A, 0, 0);   // R5 write
    issue(3'd2, 16'h0F0F, 8'hE1, 3, 0);   // R5 R6 write with waits
    issue(3'd3, 16'h907E, 8'h00, 1, 0);   // R3 I/O read
    issue(3'd4, 16'hFF33, 8'h5C, 0, 0);   // R3 I/O write
    issue(3'd1, 16'h2222, 8'h00, 1, 1);   // R8 hold raised during a cycle
    repeat (6) @(posedge clk);
    #1 hold = 1'b0;                        // R9 release
    drain();
    @(posedge clk); #1;                    // R11 request pending under hold
    hold = 1'b1; req_valid = 1'b1; req_kind = 3'd0; req_addr = 16'h4444; waits_req = 0;
    repeat (4) @(posedge clk);
    #1 hold = 1'b0;
    wait_accept();
    drain();
    issue(3'd5, 16'h0000, 8'h00, 0, 0);   // R10 halt
    repeat (4) @(posedge clk);
    #1 hold = 1'b1;                        // R8 grant from halt
    repeat (3) @(posedge clk);
    #1 hold = 1'b0;                        // R9 back to halt
    repeat (4) @(posedge clk);
    issue(3'd1, 16'h8001, 8'h00, 0, 0);   // R10 request leaves halt
    issue(3'd7, 16'h1111, 8'h00, 0, 0);   // R2 unused code acts as halt
    issue(3'd0, 16'h3C3C, 8'h00, 4, 0);
    repeat (3) @(posedge clk);
    summary();
  end
endmodule